// File: doc/BRIEF.md
# Vector Shader Add Operand Path

This block executes a single vector add in the manner of a pixel-shader arithmetic unit. A register file holds eight vectors of four signed fixed-point components, called x, y, z and w (also r, g, b, a). An add instruction names two source registers. Each source first passes through its own lane permutation and then an optional value modifier. The two shaped vectors are added lane by lane. The sum may be clamped to the unit interval. Only the lanes the instruction enables are written back into the destination register.

Instructions arrive on a valid/ready stream and complete in one cycle, with no pipelining. The register file also has a plain load path that writes a full vector, used to seed operands. It shares the single write port with the instruction stream and takes priority over it. While `ld_en` is high, `in_ready` is low and an offered instruction is held back. Otherwise `in_ready` is high. An instruction executes on the rising edge where `in_valid` and `in_ready` are both high. A combinational observation port reads any register.

Components are 16-bit signed values with 8 fractional bits: 0x0100 is one and 0x0080 is one half. The defaults for an instruction with no options are a full writemask (4'b1111), the identity swizzle (8'b11_10_01_00), modifier 2'b00 on both sources and saturate off.

Top module: `vec_add_unit`

## Requirements
- R1: After reset every component of all eight registers reads 0x0000.
- R2: When `ld_en` is high, `in_ready` is low, no instruction executes, and register `ld_idx` takes all 64 bits of `ld_data` at the clock edge. Lane i is bits [16i+15:16i].
- R3: A swizzle is four 2-bit selectors, with lane 0 in bits [1:0]. Output lane i takes the source component whose index equals selector i, so repeated indices are allowed. 8'b11_10_01_00 is the identity.
- R4: Source modifier 2'b01 subtracts 0x0080 from every swizzled component. 2'b10 multiplies every component by two. 2'b00 and 2'b11 leave the component unchanged. Each result saturates to the range [-32768, 32767].
- R5: The two modified sources are added lane by lane, and the sum saturates to the signed 16-bit range instead of wrapping.
- R6: With `in_sat` set, each result lane is clamped to [0x0000, 0x0100] before writeback.
- R7: `in_wmask` bit i enables write of lane i. Disabled lanes of the destination keep their previous value.
- R8: A source that is also the destination supplies its value from before the write.
- R9: With `in_valid` and `ld_en` both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_dst | input | 3 | Destination register |
| in_wmask | input | 4 | Lane write enables |
| in_sat | input | 1 | Clamp result to [0,1] |
| in_srca | input | 3 | First source register |
| in_swza | input | 8 | First source swizzle |
| in_moda | input | 2 | First source modifier |
| in_srcb | input | 3 | Second source register |
| in_swzb | input | 8 | Second source swizzle |
| in_modb | input | 2 | Second source modifier |
| ld_en | input | 1 | Full-vector load strobe |
| ld_idx | input | 3 | Load target register |
| ld_data | input | 64 | Load vector |
| peek_idx | input | 3 | Observation register select |
| peek_data | output | 64 | Observation register contents |

## Verification
The hardest situations to reach from the ports involve saturation inside the chain. In one, a modifier saturates before the add. In another, the add saturates and the clamp then acts on that saturated value. Both need extreme component values in exactly the lanes that a particular swizzle routes together. The bench loads registers that hold 0x7FFF, 0x8000, 0x0080 and values just past one. It sweeps every swizzle code of each source and every pairing of modifiers with and without saturate over those registers. Random instructions then follow, with periodic random reloads. A reference register model in the bench tracks the expected value of every register throughout.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int LANES = 4;
  localparam int CW    = 16;
  localparam int FRAC  = 8;
  localparam int NREG  = 8;

  typedef enum logic [1:0] {
    MOD_NONE = 2'b00,
    MOD_BIAS = 2'b01,
    MOD_DBL  = 2'b10,
    MOD_RSVD = 2'b11
  } mod_e;
endpackage

// File: rtl/vsa_regfile.sv
module vsa_regfile #(
  parameter int NREG  = 8,
  parameter int LANES = 4,
  parameter int CW    = 16,
  localparam int AW   = $clog2(NREG),
  localparam int VW   = LANES * CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LANES-1:0]  wlanes,
  input  logic [AW-1:0]     waddr,
  input  logic [VW-1:0]     wdata,
  input  logic [AW-1:0]     ra,
  input  logic [AW-1:0]     rb,
  input  logic [AW-1:0]     rp,
  output logic [VW-1:0]     qa,
  output logic [VW-1:0]     qb,
  output logic [VW-1:0]     qp,
  output logic [NREG*VW-1:0] all_q
);
  logic [VW-1:0] mem [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) mem[r][l*CW +: CW] <= '0;
        else if (we && waddr == AW'(r) && wlanes[l])
          mem[r][l*CW +: CW] <= wdata[l*CW +: CW];
      end
    end
    assign all_q[r*VW +: VW] = mem[r];
  end

  // reads see pre-edge contents
  assign qa = mem[ra];
  assign qb = mem[rb];
  assign qp = mem[rp];
endmodule

// File: rtl/vsa_operand.sv
module vsa_operand
  import vsa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 16,
  parameter int FRAC  = 8,
  localparam int SELW = $clog2(LANES),
  localparam int VW   = LANES * CW
) (
  input  logic [VW-1:0]         vec_in,
  input  logic [LANES*SELW-1:0] swz,
  input  mod_e                  mode,
  output logic [VW-1:0]         vec_out
);
  localparam logic signed [CW+1:0] MAXV = {3'b000, {(CW-1){1'b1}}};
  localparam logic signed [CW+1:0] MINV = {3'b111, {(CW-1){1'b0}}};
  localparam logic signed [CW+1:0] HALF = (CW+2)'(1) <<< (FRAC-1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SELW-1:0]        sel;
    logic signed [CW-1:0]   pick;
    logic signed [CW+1:0]   ext, shaped;

    assign sel  = swz[i*SELW +: SELW];
    assign pick = vec_in[sel*CW +: CW];
    assign ext  = {{2{pick[CW-1]}}, pick};

    always_comb begin
      unique case (mode)
        MOD_BIAS: shaped = ext - HALF;
        MOD_DBL:  shaped = ext <<< 1;
        default:  shaped = ext;
      endcase
    end

    always_comb begin
      if (shaped > MAXV)      vec_out[i*CW +: CW] = MAXV[CW-1:0];
      else if (shaped < MINV) vec_out[i*CW +: CW] = MINV[CW-1:0];
      else                    vec_out[i*CW +: CW] = shaped[CW-1:0];
    end
  end
endmodule

// File: rtl/vsa_lane_alu.sv
module vsa_lane_alu #(
  parameter int CW   = 16,
  parameter int FRAC = 8
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  input  logic          clamp,
  output logic [CW-1:0] y
);
  localparam logic signed [CW:0]   SMAX = {2'b00, {(CW-1){1'b1}}};
  localparam logic signed [CW:0]   SMIN = {2'b11, {(CW-1){1'b0}}};
  localparam logic signed [CW-1:0] ONE  = CW'(1) <<< FRAC;

  logic signed [CW:0]   sum;
  logic signed [CW-1:0] sat_sum;

  assign sum = $signed({a[CW-1], a}) + $signed({b[CW-1], b});

  always_comb begin
    if (sum > SMAX)      sat_sum = SMAX[CW-1:0];
    else if (sum < SMIN) sat_sum = SMIN[CW-1:0];
    else                 sat_sum = sum[CW-1:0];
  end

  always_comb begin
    if (!clamp)               y = sat_sum;
    else if (sat_sum < 0)     y = '0;
    else if (sat_sum > ONE)   y = ONE;
    else                      y = sat_sum;
  end
endmodule

// File: rtl/vec_add_unit.sv
module vec_add_unit
  import vsa_pkg::*;
#(
  parameter int NUM_REGS = vsa_pkg::NREG,
  parameter int NLANES   = vsa_pkg::LANES,
  parameter int COMP_W   = vsa_pkg::CW,
  parameter int FRAC_W   = vsa_pkg::FRAC,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int SELW    = $clog2(NLANES),
  localparam int VW      = NLANES * COMP_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [AW-1:0]          in_dst,
  input  logic [NLANES-1:0]      in_wmask,
  input  logic                   in_sat,
  input  logic [AW-1:0]          in_srca,
  input  logic [NLANES*SELW-1:0] in_swza,
  input  logic [1:0]             in_moda,
  input  logic [AW-1:0]          in_srcb,
  input  logic [NLANES*SELW-1:0] in_swzb,
  input  logic [1:0]             in_modb,
  input  logic                   ld_en,
  input  logic [AW-1:0]          ld_idx,
  input  logic [VW-1:0]          ld_data,
  input  logic [AW-1:0]          peek_idx,
  output logic [VW-1:0]          peek_data
);
  logic              fire;
  logic              we;
  logic [NLANES-1:0] wlanes;
  logic [AW-1:0]     waddr;
  logic [VW-1:0]     wdata;
  logic [VW-1:0]     raw_a, raw_b, opa, opb, result;
  logic [NUM_REGS*VW-1:0] rf_flat;

  assign in_ready = !ld_en;
  assign fire     = in_valid && in_ready;

  assign we     = ld_en || fire;
  assign wlanes = ld_en ? '1 : in_wmask;
  assign waddr  = ld_en ? ld_idx : in_dst;
  assign wdata  = ld_en ? ld_data : result;

  vsa_regfile #(.NREG(NUM_REGS), .LANES(NLANES), .CW(COMP_W)) u_rf (
    .clk(clk), .rst(rst), .we(we), .wlanes(wlanes), .waddr(waddr),
    .wdata(wdata), .ra(in_srca), .rb(in_srcb), .rp(peek_idx),
    .qa(raw_a), .qb(raw_b), .qp(peek_data), .all_q(rf_flat)
  );

  vsa_operand #(.LANES(NLANES), .CW(COMP_W), .FRAC(FRAC_W)) u_opa (
    .vec_in(raw_a), .swz(in_swza), .mode(mod_e'(in_moda)), .vec_out(opa)
  );

  vsa_operand #(.LANES(NLANES), .CW(COMP_W), .FRAC(FRAC_W)) u_opb (
    .vec_in(raw_b), .swz(in_swzb), .mode(mod_e'(in_modb)), .vec_out(opb)
  );

  for (genvar i = 0; i < NLANES; i++) begin : g_alu
    vsa_lane_alu #(.CW(COMP_W), .FRAC(FRAC_W)) u_alu (
      .a(opa[i*COMP_W +: COMP_W]), .b(opb[i*COMP_W +: COMP_W]),
      .clamp(in_sat), .y(result[i*COMP_W +: COMP_W])
    );
  end
endmodule

// File: rtl/vsa_checker.sv
module vsa_checker #(
  parameter int NUM_REGS = 8,
  parameter int NLANES   = 4,
  parameter int COMP_W   = 16,
  parameter int FRAC_W   = 8,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int VW      = NLANES * COMP_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   fire,
  input logic [AW-1:0]          in_dst,
  input logic [NLANES-1:0]      in_wmask,
  input logic                   in_sat,
  input logic                   ld_en,
  input logic [AW-1:0]          ld_idx,
  input logic [VW-1:0]          ld_data,
  input logic [NUM_REGS*VW-1:0] rf_flat
);
  localparam logic signed [COMP_W-1:0] ONE = COMP_W'(1) <<< FRAC_W;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
    // R2: loaded register holds the load vector after the edge
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (ld_en && ld_idx == AW'(r)) |=> rf_flat[r*VW +: VW] == $past(ld_data));

    for (genvar l = 0; l < NLANES; l++) begin : g_l
      // R7: masked-off lane of the destination is untouched
      assert_mask_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && in_dst == AW'(r) && !in_wmask[l])
        |=> $stable(rf_flat[r*VW + l*COMP_W +: COMP_W]));

      // R6: clamped lane lies in [0, one]
      assert_sat_range_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && in_dst == AW'(r) && in_wmask[l] && in_sat)
        |=> ($signed(rf_flat[r*VW + l*COMP_W +: COMP_W]) >= 0 &&
             $signed(rf_flat[r*VW + l*COMP_W +: COMP_W]) <= ONE));
    end
  end

  // R9: idle cycle changes nothing
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !ld_en) |=> $stable(rf_flat));
endmodule

bind vec_add_unit vsa_checker #(
  .NUM_REGS(NUM_REGS), .NLANES(NLANES), .COMP_W(COMP_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fire(fire), .in_dst(in_dst),
  .in_wmask(in_wmask), .in_sat(in_sat), .ld_en(ld_en), .ld_idx(ld_idx),
  .ld_data(ld_data), .rf_flat(rf_flat)
);

// File: tb/vec_add_unit_test.sv
module vec_add_unit_test;
  logic        clk = 0;
  logic        rst;
  logic        in_valid, in_ready, in_sat, ld_en;
  logic [2:0]  in_dst, in_srca, in_srcb, ld_idx, peek_idx;
  logic [3:0]  in_wmask;
  logic [7:0]  in_swza, in_swzb;
  logic [1:0]  in_moda, in_modb;
  logic [63:0] ld_data, peek_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] mdl [8];

  always #5 clk = ~clk;

  vec_add_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_wmask(in_wmask), .in_sat(in_sat),
    .in_srca(in_srca), .in_swza(in_swza), .in_moda(in_moda),
    .in_srcb(in_srcb), .in_swzb(in_swzb), .in_modb(in_modb),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int shape(int v, logic [1:0] m);
    if (m == 2'b01) return sat16(v - 128);
    if (m == 2'b10) return sat16(v * 2);
    return v;
  endfunction

  function automatic logic [63:0] model_op(logic [63:0] old, logic [63:0] va,
      logic [63:0] vb, logic [3:0] wm, logic sat, logic [7:0] swa,
      logic [1:0] ma, logic [7:0] swb, logic [1:0] mb);
    logic [63:0] res = old;
    for (int i = 0; i < 4; i++) begin
      int a, b, s;
      logic [15:0] ca, cb;
      ca = va[16*swa[2*i +: 2] +: 16];
      cb = vb[16*swb[2*i +: 2] +: 16];
      a = shape(int'($signed(ca)), ma);
      b = shape(int'($signed(cb)), mb);
      s = sat16(a + b);
      if (sat) s = (s < 0) ? 0 : ((s > 256) ? 256 : s);
      if (wm[i]) res[16*i +: 16] = 16'(s);
    end
    return res;
  endfunction

  task automatic check_reg(input int r, input string req);
    @(negedge clk);
    peek_idx = 3'(r);
    #1;
    checks++;
    if (peek_data !== mdl[r]) begin
      errors++;
      $display("FAIL %s reg%0d actual %h expected %h", req, r, peek_data, mdl[r]);
    end
  endtask

  task automatic load(input int r, input logic [63:0] d);
    @(negedge clk);
    ld_en = 1; ld_idx = 3'(r); ld_data = d;
    @(negedge clk);
    ld_en = 0;
    mdl[r] = d;
  endtask

  task automatic do_op(input int dst, input logic [3:0] wm, input logic sat,
      input int sa, input logic [7:0] swa, input logic [1:0] ma,
      input int sb, input logic [7:0] swb, input logic [1:0] mb,
      input string req);
    logic [63:0] exp;
    exp = model_op(mdl[dst], mdl[sa], mdl[sb], wm, sat, swa, ma, swb, mb);
    @(negedge clk);
    in_valid = 1; in_dst = 3'(dst); in_wmask = wm; in_sat = sat;
    in_srca = 3'(sa); in_swza = swa; in_moda = ma;
    in_srcb = 3'(sb); in_swzb = swb; in_modb = mb;
    @(negedge clk);
    in_valid = 0;
    mdl[dst] = exp;
    peek_idx = 3'(dst);
    #1;
    checks++;
    if (peek_data !== exp) begin
      errors++;
      $display("FAIL %s dst%0d actual %h expected %h", req, dst, peek_data, exp);
    end
  endtask

  initial begin
    rst = 1; in_valid = 0; ld_en = 0; in_sat = 0;
    in_dst = 0; in_wmask = 4'hF; in_srca = 0; in_srcb = 0;
    in_swza = 8'hE4; in_swzb = 8'hE4; in_moda = 0; in_modb = 0;
    ld_idx = 0; ld_data = 0; peek_idx = 0;
    for (int r = 0; r < 8; r++) mdl[r] = 64'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: reset state
    for (int r = 0; r < 8; r++) check_reg(r, "R1");

    // R2: loads with extreme and fractional values
    load(0, {16'h7FF0, 16'hFF00, 16'h0080, 16'h0100});
    load(1, {16'h8000, 16'h7FFF, 16'h0140, 16'hFFC0});
    load(2, {16'h0180, 16'h0040, 16'hC000, 16'h4000});
    load(3, {16'h0001, 16'hFFFF, 16'h0100, 16'h00FF});
    load(4, {16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000});
    load(5, {16'h0300, 16'hFE00, 16'h0000, 16'h0081});
    load(6, {16'h1234, 16'hEDCB, 16'h0200, 16'hFF80});
    load(7, {16'h0010, 16'h0020, 16'h0030, 16'h0040});
    for (int r = 0; r < 8; r++) check_reg(r, "R2");

    // R2: load takes priority, instruction held back
    @(negedge clk);
    ld_en = 1; ld_idx = 3'd5; ld_data = 64'h0101_0202_0303_0404;
    in_valid = 1; in_dst = 3'd6; in_wmask = 4'hF; in_srca = 0; in_srcb = 1;
    #1;
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R2 in_ready actual %b expected 0", in_ready);
    end
    @(negedge clk);
    ld_en = 0; in_valid = 0;
    mdl[5] = 64'h0101_0202_0303_0404;
    check_reg(5, "R2");
    check_reg(6, "R2");
    load(5, {16'h0300, 16'hFE00, 16'h0000, 16'h0081});

    // R9: fields set but no valid, nothing changes
    @(negedge clk);
    in_valid = 0; in_dst = 3'd3; in_srca = 3'd4; in_srcb = 3'd4;
    repeat (2) @(negedge clk);
    for (int r = 0; r < 8; r++) check_reg(r, "R9");

    // R3: every swizzle code on each source
    for (int s = 0; s < 256; s++)
      do_op(7, 4'hF, 0, 6, 8'(s), 2'b00, 3, 8'hE4, 2'b00, "R3");
    for (int s = 0; s < 256; s++)
      do_op(7, 4'hF, 0, 3, 8'hE4, 2'b00, 6, 8'(s), 2'b00, "R3");

    // R4 R5 R6: modifier pairs with and without clamp over extreme sources
    for (int p = 0; p < 8; p++)
      for (int ma = 0; ma < 4; ma++)
        for (int mb = 0; mb < 4; mb++)
          for (int sat = 0; sat < 2; sat++) begin
            do_op(7, 4'hF, sat[0], p, 8'h1B, 2'(ma), (p + 1) % 7, 8'hE4,
                  2'(mb), sat ? "R6" : "R4");
            load(7, {16'h0010, 16'h0020, 16'h0030, 16'h0040});
          end
    do_op(7, 4'hF, 0, 4, 8'hE4, 2'b10, 4, 8'hE4, 2'b10, "R5");
    do_op(7, 4'hF, 1, 4, 8'hE4, 2'b01, 4, 8'hE4, 2'b00, "R6");

    // R7: every writemask
    for (int m = 0; m < 16; m++) begin
      load(7, {16'h0010, 16'h0020, 16'h0030, 16'h0040});
      do_op(7, 4'(m), 0, 0, 8'hE4, 2'b00, 1, 8'h4E, 2'b00, "R7");
    end

    // R8: destination also a source
    do_op(2, 4'hF, 0, 2, 8'hE4, 2'b00, 2, 8'h1B, 2'b00, "R8");
    do_op(2, 4'h5, 0, 2, 8'h00, 2'b10, 2, 8'hFF, 2'b01, "R8");

    // mixed random traffic with occasional reloads
    for (int k = 0; k < 1500; k++) begin
      if (k % 50 == 0) load($urandom_range(0, 7), {$urandom, $urandom});
      do_op($urandom_range(0, 7), 4'($urandom), 1'($urandom),
            $urandom_range(0, 7), 8'($urandom), 2'($urandom),
            $urandom_range(0, 7), 8'($urandom), 2'($urandom), "R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule